// File: doc/BRIEF.md
# External Bus Width-Adapting Access Controller

This block is a master on an external peripheral bus. It accepts a single 32-bit CPU access, either a read or a write. It decodes the width of the addressed device from the address window the access falls in. It then runs one, two or four device cycles on the external pins. A write is split into narrow device cycles, lowest byte first. A read collects the narrow results and returns them as one 32-bit word. The CPU sees a single ready pulse when the whole sequence has finished.

Two pin modes are available. In multiplexed mode, each device cycle starts with a one-cycle address phase. In that phase the full 32-bit address is placed on the shared AD bus and an address latch enable pulse is given. The strobe phase follows. In demultiplexed mode, the low 24 address bits appear on dedicated address pins and data uses only the low 16 AD lines. Each strobe phase lasts a programmable minimum number of wait cycles. It is stretched further until the device acknowledges.

Top module: `ebsg_ctrl`

## Requirements
- R1: The device width comes from the address window. Addresses with bits [31:26] = 6'b000100 select a 32-bit device and give 1 cycle with eb_be_n = 4'b0000. Bits [31:26] = 6'b000101 select a 16-bit device and give 2 cycles with eb_be_n = 4'b1100. Bits [31:26] = 6'b000110 select an 8-bit device and give 4 cycles with eb_be_n = 4'b1110.
- R2: Device cycle k uses byte address {cpu_addr[31:2],2'b00} + k*(device bytes). On a write, cycle k drives cpu_wdata bits [8*k*bytes +: 8*bytes] on the low AD lines with eb_ad_oe = 1 through the strobe. On a read, eb_ad_oe = 0 through the strobe.
- R3: A read returns, on cpu_rdata, the bytes captured in cycle order and packed little-endian into one word. Each cycle's data is sampled in the cycle that ends its strobe.
- R4: Exactly one chip select, index 2*cpu_addr[27:26] + cpu_addr[24], is low during the address and strobe phases. All chip selects are high otherwise.
- R5: In multiplexed mode (cfg_mux = 1), every strobe is preceded by exactly one cycle with eb_ale = 1, with eb_ad_oe = 1 and the full 32-bit cycle address on eb_ad_o.
- R6: In demultiplexed mode (cfg_mux = 0), eb_ale stays 0 and eb_addr carries the low 24 bits of the cycle address. A 32-bit window access runs as two 16-bit cycles (eb_be_n = 4'b1100).
- R7: A strobe (eb_rd_n for reads, eb_wr_n for writes) stays low for max(cfg_wait, A) + 1 cycles. Here A is the number of strobe cycles before eb_ack_n goes low. The two strobes are never low together.
- R8: Between successive cycles of one access, the strobes are high for exactly 1 cycle in demultiplexed mode. In multiplexed mode they are high for 2 cycles: the recovery cycle plus the address phase.
- R9: cpu_ready is high for exactly one cycle per access, after the last device cycle has ended. An access outside all three windows gives the ready pulse with no strobe, no chip select and cpu_rdata = 0.
- R10: After reset, all chip selects and both strobes are high, eb_ale = 0, eb_ad_oe = 0 and cpu_ready = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mux | input | 1 | 1 = multiplexed address/data pins, 0 = separate address pins |
| cfg_wait | input | WAIT_W | Minimum wait cycles per strobe |
| cpu_req | input | 1 | Access request, taken when the block is idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Assembled read word, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| eb_cs_n | output | NCS | Active-low chip selects |
| eb_be_n | output | 4 | Active-low byte-lane enables |
| eb_ale | output | 1 | Address latch enable (multiplexed mode) |
| eb_rd_n | output | 1 | Active-low read strobe |
| eb_wr_n | output | 1 | Active-low write strobe |
| eb_ack_n | input | 1 | Active-low device acknowledge |
| eb_addr | output | 24 | Low address bits of the current cycle |
| eb_ad_o | output | 32 | AD bus output value |
| eb_ad_oe | output | 1 | AD bus output enable |
| eb_ad_i | input | 32 | AD bus input value |

## Verification
Writes and reads are issued to all three windows in multiplexed mode and to the narrow windows in demultiplexed mode. This separates the lane, byte-enable and address-step choices for each width. The device model returns a byte that depends on its address, so a wrong cycle order or a wrong lane in the gather shows up as a wrong byte.

Wait counts are run both above and below the device's acknowledge delay. This shows whether the strobe length follows the larger of the two. Addresses with bit 24 set, non-zero low bits, and one outside every window check chip-select indexing, word alignment and the path that finishes with no bus cycle.

// File: rtl/ebsg_pkg.sv
// Shared types for the external bus width-adapting controller.
// Assumes: a 32-bit CPU word and at most four device cycles per access.
package ebsg_pkg;

    // Effective device port width of the current access.
    typedef enum logic [1:0] {
        PW_NONE = 2'd0,
        PW_8    = 2'd1,
        PW_16   = 2'd2,
        PW_32   = 2'd3
    } port_w_e;

    // Sequencer phases.
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ADDR = 3'd1,
        S_STRB = 3'd2,
        S_GAP  = 3'd3,
        S_DONE = 3'd4
    } seq_st_e;

endpackage

// File: rtl/ebsg_decode.sv
// Window decoder: maps the high address bits to a device width and a
// one-hot chip select. Assumes three 64 MB windows from 0x1000_0000, with
// two selects per window chosen by the bit just above the device offset.
// In demultiplexed mode the data path is 16 bits, so 32-bit becomes 16-bit.
module ebsg_decode
    import ebsg_pkg::*;
#(
    parameter int NCS   = 6,
    parameter int OFF_W = 24
) (
    input  logic [31:OFF_W] addr_hi,
    input  logic            cfg_mux,
    output port_w_e         width,
    output logic            valid,
    output logic [NCS-1:0]  cs_sel
);
    localparam int IDX_W = $clog2(NCS);

    logic [1:0]       win;
    logic [IDX_W-1:0] cs_idx;
    logic             unused_hi;

    assign win       = addr_hi[27:26];
    assign valid     = (addr_hi[31:28] == 4'h1) && (win != 2'b11);
    assign cs_idx    = IDX_W'({win, addr_hi[OFF_W]});
    assign unused_hi = ^addr_hi[25:OFF_W+1];

    // Width selection from the window, narrowed in demultiplexed mode.
    always_comb begin
        width = PW_NONE;
        if (valid) begin
            unique case (win)
                2'b00:   width = cfg_mux ? PW_32 : PW_16;
                2'b01:   width = PW_16;
                default: width = PW_8;
            endcase
        end
    end

    // One-hot chip select per output position.
    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_sel[i] = valid && (cs_idx == IDX_W'(i));
    end

endmodule

// File: rtl/ebsg_lane.sv
// Lane steering: for the current cycle index, picks the write lanes,
// byte enables and the byte offset, and merges read lanes into the
// gathered word. Assumes narrow devices sit on the low byte lanes.
module ebsg_lane
    import ebsg_pkg::*;
#(
    parameter int DW = 32
) (
    input  port_w_e         width,
    input  logic [1:0]      beat,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   ad_i,
    input  logic [DW-1:0]   gather_q,
    output logic [DW-1:0]   lane_out,
    output logic [DW/8-1:0] be_n,
    output logic [2:0]      beat_off,
    output logic            last_beat,
    output logic [DW-1:0]   gather_next
);
    localparam int NL = DW / 8;

    // Write lane extraction and byte enables per width.
    always_comb begin
        lane_out = '0;
        be_n     = '1;
        beat_off = 3'd0;
        unique case (width)
            PW_32: begin
                lane_out = wdata;
                be_n     = '0;
            end
            PW_16: begin
                lane_out[15:0] = wdata[beat[0]*16 +: 16];
                be_n           = {{(NL-2){1'b1}}, 2'b00};
                beat_off       = {1'b0, beat[0], 1'b0};
            end
            PW_8: begin
                lane_out[7:0] = wdata[beat*8 +: 8];
                be_n          = {{(NL-1){1'b1}}, 1'b0};
                beat_off      = {1'b0, beat};
            end
            default: ;
        endcase
    end

    // Last cycle of the sequence for the current width.
    always_comb begin
        unique case (width)
            PW_16:   last_beat = beat[0];
            PW_8:    last_beat = (beat == 2'd3);
            default: last_beat = 1'b1;
        endcase
    end

    // Merge incoming lanes into their slot of the gathered word.
    always_comb begin
        gather_next = gather_q;
        unique case (width)
            PW_32:   gather_next = ad_i;
            PW_16:   gather_next[beat[0]*16 +: 16] = ad_i[15:0];
            PW_8:    gather_next[beat*8 +: 8] = ad_i[7:0];
            default: ;
        endcase
    end

endmodule

// File: rtl/ebsg_seq.sv
// Cycle sequencer: walks address, strobe and recovery phases for each
// device cycle, counts wait cycles, and ends a strobe once the count is
// zero and the acknowledge is low. Assumes cfg_* stay stable during an access.
module ebsg_seq
    import ebsg_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              valid,
    input  logic              cfg_mux,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              last_beat,
    input  logic              eb_ack_n,
    output seq_st_e           st,
    output logic [1:0]        beat,
    output logic              capture,
    output logic              done
);
    logic [WAIT_W-1:0] wcnt;
    logic              strobe_end;

    assign strobe_end = (st == S_STRB) && (wcnt == '0) && !eb_ack_n;
    assign capture    = strobe_end;
    assign done       = (st == S_DONE);

    // Phase, cycle-index and wait-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            beat <= 2'd0;
            wcnt <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    beat <= 2'd0;
                    wcnt <= cfg_wait;
                    if (!valid)       st <= S_DONE;
                    else if (cfg_mux) st <= S_ADDR;
                    else              st <= S_STRB;
                end
                S_ADDR: begin
                    wcnt <= cfg_wait;
                    st   <= S_STRB;
                end
                S_STRB: begin
                    if (wcnt != '0) wcnt <= wcnt - 1'b1;
                    if (strobe_end) st <= last_beat ? S_DONE : S_GAP;
                end
                S_GAP: begin
                    beat <= beat + 2'd1;
                    wcnt <= cfg_wait;
                    st   <= cfg_mux ? S_ADDR : S_STRB;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ebsg_ctrl.sv
// Top of the external bus width-adapting controller. Takes one 32-bit
// CPU access, latches it, and drives the device cycles that the window's
// width needs. Assumes a new request only arrives while idle.
module ebsg_ctrl
    import ebsg_pkg::*;
#(
    parameter int NCS    = 6,
    parameter int WAIT_W = 4,
    parameter int OFF_W  = 24,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mux,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [31:0]       cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic              cpu_ready,
    output logic [NCS-1:0]    eb_cs_n,
    output logic [DW/8-1:0]   eb_be_n,
    output logic              eb_ale,
    output logic              eb_rd_n,
    output logic              eb_wr_n,
    input  logic              eb_ack_n,
    output logic [OFF_W-1:0]  eb_addr,
    output logic [DW-1:0]     eb_ad_o,
    output logic              eb_ad_oe,
    input  logic [DW-1:0]     eb_ad_i
);
    localparam int NL = DW / 8;

    port_w_e        dec_width, width_q;
    logic           dec_valid, valid_q;
    logic [NCS-1:0] dec_cs, cs_q;
    logic           we_q;
    logic [31:2]    base_q;
    logic [DW-1:0]  wd_q, gather_q, gather_next, lane_out;
    logic [NL-1:0]  lane_be_n;
    logic [2:0]     beat_off;
    logic           last_beat, capture, done, start, active;
    logic [1:0]     beat;
    seq_st_e        st;
    logic [31:0]    beat_addr;
    logic           unused_lo;

    assign unused_lo = ^{cpu_addr[1:0], valid_q};

    ebsg_decode #(.NCS(NCS), .OFF_W(OFF_W)) u_dec (
        .addr_hi (cpu_addr[31:OFF_W]),
        .cfg_mux (cfg_mux),
        .width   (dec_width),
        .valid   (dec_valid),
        .cs_sel  (dec_cs)
    );

    ebsg_lane #(.DW(DW)) u_lane (
        .width       (width_q),
        .beat        (beat),
        .wdata       (wd_q),
        .ad_i        (eb_ad_i),
        .gather_q    (gather_q),
        .lane_out    (lane_out),
        .be_n        (lane_be_n),
        .beat_off    (beat_off),
        .last_beat   (last_beat),
        .gather_next (gather_next)
    );

    ebsg_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .valid     (dec_valid),
        .cfg_mux   (cfg_mux),
        .cfg_wait  (cfg_wait),
        .last_beat (last_beat),
        .eb_ack_n  (eb_ack_n),
        .st        (st),
        .beat      (beat),
        .capture   (capture),
        .done      (done)
    );

    assign start = cpu_req && (st == S_IDLE);

    // Latch the access and its decoded attributes at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            base_q  <= '0;
            wd_q    <= '0;
            width_q <= PW_NONE;
            valid_q <= 1'b0;
            cs_q    <= '0;
        end else if (start) begin
            we_q    <= cpu_we;
            base_q  <= cpu_addr[31:2];
            wd_q    <= cpu_wdata;
            width_q <= dec_width;
            valid_q <= dec_valid;
            cs_q    <= dec_cs;
        end
    end

    // Gathered read word, cleared per access and filled per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 gather_q <= '0;
        else if (start)             gather_q <= '0;
        else if (capture && !we_q)  gather_q <= gather_next;
    end

    assign beat_addr = {base_q, 2'b00} + {29'd0, beat_off};
    assign active    = (st == S_ADDR) || (st == S_STRB);

    // Pin drive from the current phase.
    always_comb begin
        eb_cs_n  = active ? ~cs_q : '1;
        eb_be_n  = active ? lane_be_n : '1;
        eb_ale   = (st == S_ADDR);
        eb_rd_n  = !((st == S_STRB) && !we_q);
        eb_wr_n  = !((st == S_STRB) && we_q);
        eb_addr  = active ? beat_addr[OFF_W-1:0] : '0;
        eb_ad_oe = (st == S_ADDR) || ((st == S_STRB) && we_q);
        if (st == S_ADDR)              eb_ad_o = DW'(beat_addr);
        else if (st == S_STRB && we_q) eb_ad_o = lane_out;
        else                           eb_ad_o = '0;
    end

    assign cpu_ready = done;
    assign cpu_rdata = gather_q;

endmodule

// File: rtl/ebsg_chk.sv
// Property checker for ebsg_ctrl, attached by bind below. Assumes the
// synchronous active-low reset of the controller.
module ebsg_chk #(
    parameter int NCS = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_mux,
    input logic           eb_ale,
    input logic           eb_rd_n,
    input logic           eb_wr_n,
    input logic [NCS-1:0] eb_cs_n,
    input logic           eb_ad_oe,
    input logic           cpu_ready
);
    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!eb_rd_n && !eb_wr_n));
    // R4
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~eb_cs_n));
    // R4
    strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eb_rd_n || !eb_wr_n) |-> (eb_cs_n != '1));
    // R5
    ale_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eb_ale |=> (!eb_rd_n || !eb_wr_n));
    // R6
    demux_no_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mux |-> !eb_ale);
    // R2
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eb_rd_n |-> !eb_ad_oe);
    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
    // R10
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (eb_cs_n == '1 && eb_rd_n && eb_wr_n && !eb_ale && !cpu_ready));
endmodule

bind ebsg_ctrl ebsg_chk #(.NCS(NCS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mux   (cfg_mux),
    .eb_ale    (eb_ale),
    .eb_rd_n   (eb_rd_n),
    .eb_wr_n   (eb_wr_n),
    .eb_cs_n   (eb_cs_n),
    .eb_ad_oe  (eb_ad_oe),
    .cpu_ready (cpu_ready)
);

// File: tb/test_ebsg_ctrl.sv
// Scoreboard bench: the access task queues the expected device cycles,
// the monitor pops and compares them as strobes begin.
module test_ebsg_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mux = 1'b1;
    logic [3:0]  cfg_wait = 4'd0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic [5:0]  eb_cs_n;
    logic [3:0]  eb_be_n;
    logic        eb_ale, eb_rd_n, eb_wr_n, eb_ack_n, eb_ad_oe;
    logic [23:0] eb_addr;
    logic [31:0] eb_ad_o, eb_ad_i;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    ebsg_ctrl i_ebsg_ctrl (.*);

    // Device model: address-dependent bytes, acknowledge after a delay.
    function automatic logic [7:0] dbyte(input logic [23:0] a);
        return (a[7:0] ^ 8'hC3) + a[15:8];
    endfunction

    logic [7:0] ack_dly = 8'd0;
    logic [7:0] scnt = 8'd0;
    logic       strobe_w;
    assign strobe_w = !eb_rd_n || !eb_wr_n;
    always @(posedge clk) scnt <= strobe_w ? scnt + 8'd1 : 8'd0;
    assign eb_ack_n = !(strobe_w && (scnt >= ack_dly));
    assign eb_ad_i  = {dbyte(eb_addr + 24'd3), dbyte(eb_addr + 24'd2),
                       dbyte(eb_addr + 24'd1), dbyte(eb_addr)};

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct {
        logic [31:0] addr;
        logic [3:0]  be;
        int          cs;
        logic        we;
        logic [31:0] data;
        logic [31:0] mask;
    } beat_t;

    beat_t q[$];
    beat_t cur;
    int exp_len = 1;
    int slen = 0;
    int hi_cnt = 0;
    int beat_no = 0;
    int ale_cnt = 0;
    int starts = 0;
    logic        prev_strobe = 1'b0;
    logic        prev_ale = 1'b0;
    logic [31:0] ale_addr = '0;

    // Monitor: compares each strobe against the head of the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (strobe_w && !prev_strobe) begin
                starts++;
                if (q.size() == 0) begin
                    chk(1'b0, "R1 extra cycle", 32'd1, 32'd0);
                end else begin
                    cur = q.pop_front();
                    chk(eb_addr == cur.addr[23:0], "R2 cycle address", {8'd0, eb_addr}, cur.addr);
                    chk(eb_be_n == cur.be, "R1 byte enables", {28'd0, eb_be_n}, {28'd0, cur.be});
                    chk(eb_cs_n == ~(6'd1 << cur.cs), "R4 chip select", {26'd0, eb_cs_n}, {26'd0, ~(6'd1 << cur.cs)});
                    chk(eb_wr_n == !cur.we, "R7 strobe kind", {31'd0, eb_wr_n}, {31'd0, !cur.we});
                    chk(eb_ad_oe == cur.we, "R2 AD drive", {31'd0, eb_ad_oe}, {31'd0, cur.we});
                    if (cur.we)
                        chk((eb_ad_o & cur.mask) == cur.data, "R2 write lanes", eb_ad_o & cur.mask, cur.data);
                    if (cfg_mux) begin
                        chk(prev_ale && ale_addr == cur.addr, "R5 address phase", ale_addr, cur.addr);
                    end else begin
                        chk(ale_cnt == 0, "R6 no ALE", ale_cnt, 0);
                    end
                    if (beat_no > 0)
                        chk(hi_cnt == (cfg_mux ? 2 : 1), "R8 gap", hi_cnt, cfg_mux ? 2 : 1);
                    beat_no++;
                end
                slen = 1;
            end else if (strobe_w) begin
                slen++;
            end else if (prev_strobe) begin
                chk(slen == exp_len, "R7 strobe length", slen, exp_len);
                hi_cnt = 1;
            end else begin
                hi_cnt++;
            end
            if (eb_ale) begin
                ale_cnt++;
                ale_addr = eb_ad_o;
                if (!eb_ad_oe) chk(1'b0, "R5 AD enable", 32'd0, 32'd1);
            end
            prev_ale    = eb_ale;
            prev_strobe = strobe_w;
        end
    end

    // Driver: queue expected cycles, issue the request, check completion.
    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          input logic mux, input int wt, input int ad);
        int bytes, nb, win, st0, n;
        logic [31:0] base, exp_rd;
        beat_t b;
        @(negedge clk);
        cfg_mux  = mux;
        cfg_wait = 4'(wt);
        ack_dly  = 8'(ad);
        exp_len  = (wt > ad ? wt : ad) + 1;
        beat_no  = 0;
        ale_cnt  = 0;
        base = {addr[31:2], 2'b00};
        win  = int'(addr[27:26]);
        exp_rd = '0;
        if (addr[31:28] == 4'h1 && win != 3) begin
            bytes = (win == 0) ? (mux ? 4 : 2) : (win == 1 ? 2 : 1);
            nb = 4 / bytes;
            for (int k = 0; k < nb; k++) begin
                b.addr = base + 32'(k * bytes);
                b.be   = (bytes == 4) ? 4'b0000 : (bytes == 2 ? 4'b1100 : 4'b1110);
                b.cs   = 2 * win + int'(addr[24]);
                b.we   = we;
                b.mask = (bytes == 4) ? 32'hFFFF_FFFF : (bytes == 2 ? 32'h0000_FFFF : 32'h0000_00FF);
                b.data = (wd >> (8 * k * bytes)) & b.mask;
                q.push_back(b);
            end
            for (int i = 0; i < 4; i++) exp_rd[8*i +: 8] = dbyte(base[23:0] + 24'(i));
        end
        st0 = starts;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        n = 0;
        while (!cpu_ready && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(cpu_ready, "R9 ready seen", {31'd0, cpu_ready}, 32'd1);
        chk(q.size() == 0, "R9 ready after last cycle", q.size(), 0);
        if (!we) chk(cpu_rdata == exp_rd, "R3 gathered word", cpu_rdata, exp_rd);
        if (exp_rd == '0 && addr[27:26] == 2'b11 || addr[31:28] != 4'h1)
            chk(starts == st0, "R9 no cycle outside windows", starts - st0, 0);
        @(negedge clk);
        chk(!cpu_ready, "R9 single pulse", {31'd0, cpu_ready}, 32'd0);
        q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(eb_cs_n == 6'h3F && eb_rd_n && eb_wr_n && !eb_ale && !eb_ad_oe && !cpu_ready,
            "R10 reset state", {26'd0, eb_cs_n}, 32'h3F);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R2 R5 multiplexed writes to each window
        access(1'b1, 32'h1000_0104, 32'hA1B2_C3D4, 1'b1, 0, 0);
        access(1'b1, 32'h1100_0200, 32'h1122_3344, 1'b1, 3, 1);
        access(1'b1, 32'h1400_0010, 32'h5566_7788, 1'b1, 2, 5);
        access(1'b1, 32'h1900_0020, 32'h99AA_BBCC, 1'b1, 1, 0);
        // R3 multiplexed reads
        access(1'b0, 32'h1000_0340, 32'h0, 1'b1, 1, 2);
        access(1'b0, 32'h1500_0452, 32'h0, 1'b1, 0, 3);
        access(1'b0, 32'h1800_0563, 32'h0, 1'b1, 4, 0);
        // R6 demultiplexed mode
        access(1'b1, 32'h1000_1200, 32'hDEAD_BEEF, 1'b0, 0, 1);
        access(1'b0, 32'h1101_0A04, 32'h0, 1'b0, 2, 2);
        access(1'b0, 32'h1500_0A04, 32'h0, 1'b0, 1, 0);
        access(1'b1, 32'h1800_0F0C, 32'h0102_0304, 1'b0, 0, 0);
        access(1'b0, 32'h1900_7777, 32'h0, 1'b0, 3, 1);
        // R9 outside all windows
        access(1'b0, 32'h1C00_0000, 32'h0, 1'b1, 0, 0);
        access(1'b1, 32'h2000_0000, 32'hFFFF_FFFF, 1'b0, 0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule